// File: doc/BRIEF.md
# Per-Block Read-Disturb Monitor

Reading one page of a flash block slowly disturbs the cells around it. After enough reads since the block's last erase, the stored data must be moved elsewhere before it decays past what error correction can fix. This monitor keeps one read counter for every block. Each counter counts the page reads seen since that block was last erased. When a block's count goes above a programmable threshold, the monitor asks for that block to be refreshed. The flash controller then copies the block, erases it and returns it to service.

The monitor sees one event per cycle: a page read of a block, or an erase of a block. Every event is a read-modify-write of a per-block entry held in an inferred RAM. A bypass register covers back-to-back events that hit the same block. Refresh requests wait in a small valid/ready queue. Each block gets one request per crossing, guarded by a per-block "requested" mark that only an erase clears. When the queue is full, the request is not lost: the next read of that block offers it again. Counters stop at their maximum value and do not wrap. A one-cycle flag reports a read that found its counter already at the maximum.

Top module: `read_disturb_monitor`

## Requirements
- R1: After reset every block count is zero and no block is marked requested; `req_valid` and `sat_hit` are 0.
- R2: A read event (`ev_valid`=1, `ev_erase`=0) adds one to the count of block `ev_blk` only; the counts of other blocks are unchanged.
- R3: A read that leaves a block's count strictly greater than `threshold`, on a block not marked requested, pushes that block index into the request queue and marks the block. For an event sampled at clock edge k, a push into an empty queue makes `req_valid`=1 with `req_blk` equal to the block after edge k+1.
- R4: While a block is marked requested, further reads of it push no new request, even after the queued request has been taken.
- R5: An erase event (`ev_valid`=1, `ev_erase`=1) sets the block's count to zero and clears its requested mark; requests already queued stay in the queue.
- R6: Events on the same block in consecutive cycles are each applied in order; none is lost and none is applied twice.
- R7: If the queue is full when a request would be pushed, the request is dropped and the block stays unmarked, so the next read of that block that finds room pushes it.
- R8: A count equal to all ones (2^CNT_W-1) stays there on further reads. Such a read pulses `sat_hit` high for exactly one cycle, after edge k+1 for an event sampled at edge k. A saturated count still takes part in the threshold compare of R3.
- R9: The queue hands out block indices in the order they were pushed. One entry leaves at each clock edge where `req_valid` and `req_ready` are both 1.
- R10: A cycle with `ev_valid`=0 changes no count and no mark, whatever `ev_erase` and `ev_blk` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_erase | input | 1 | 1 = erase event, 0 = page-read event |
| ev_blk | input | BLK_W | Block index of the event |
| threshold | input | CNT_W | A count strictly above this value triggers a refresh request |
| req_valid | output | 1 | Refresh queue holds at least one block index |
| req_ready | input | 1 | Controller takes the head entry of the queue |
| req_blk | output | BLK_W | Block index at the head of the queue |
| sat_hit | output | 1 | One-cycle pulse: a read found its counter already at maximum |

## Verification
The bench sweeps every threshold below the counter maximum on every block of a small configuration. In each case the request must appear on exactly read threshold+1: an off-by-one compare shows up as a request one read early or late. Bursts of same-block events, including read-erase-read sequences, go after the write-back bypass. A missing or stale bypass loses increments, or keeps a requested mark that an erase should have cleared. The bench also fills the queue so that a request is dropped, then checks that a later read offers it again. Last, it drives a counter to saturation and checks that the count does not wrap back below the threshold, and that the flag pulses only on reads that find the counter already at the maximum.

// File: rtl/rdm_pkg.sv
// Package rdm_pkg
// Shared encodings for the read-disturb monitor.
// Assumes: one event per cycle; the event kind is a single bit.
package rdm_pkg;

    // Event kind carried on ev_erase
    typedef enum logic {
        OP_READ  = 1'b0,
        OP_ERASE = 1'b1
    } rdm_op_e;

    // Width of one stored entry: the count plus the requested mark
    function automatic int entry_width(input int cnt_w);
        return cnt_w + 1;
    endfunction

endpackage

// File: rtl/rdm_count_ram.sv
// Module rdm_count_ram
// Simple dual-port storage with one write port and one registered read port,
// written so that it maps onto an inferred block RAM.
// Assumes: a read and a write to the same address in one cycle returns the
// old data (read-before-write); the caller bypasses that case itself.
// Contents are not reset; the caller masks entries never written.
module rdm_count_ram #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 21,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Write port and registered read port
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/rdm_req_fifo.sv
// Module rdm_req_fifo
// First-in first-out queue of block indices with a show-ahead head.
// Assumes: DEPTH is a power of two and at least 2; the producer never pushes
// while full; the consumer pops only while the head is valid.
module rdm_req_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 10,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         full,
    input  logic         pop,
    output logic         head_valid,
    output logic [W-1:0] head_data
);

    logic [W-1:0] store [DEPTH];
    logic [AW:0]  wr_ptr;
    logic [AW:0]  rd_ptr;
    logic         empty;

    // Occupancy flags from the wrap bit and the index bits
    always_comb begin
        empty = (wr_ptr == rd_ptr);
        full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    end

    // Write pointer advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (push && !full) begin
            wr_ptr <= wr_ptr + 1'b1;
        end
    end

    // Read pointer advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (pop && !empty) begin
            rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Entry storage, not reset
    always_ff @(posedge clk) begin
        if (push && !full) begin
            store[wr_ptr[AW-1:0]] <= push_data;
        end
    end

    // Show-ahead head
    always_comb begin
        head_valid = !empty;
        head_data  = store[rd_ptr[AW-1:0]];
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);                                              // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);                                          // R9
    AST_POP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> !full);                                    // R9

endmodule

// File: rtl/rdm_update.sv
// Module rdm_update
// Next-state logic for one block entry: saturating increment on a read,
// clear on an erase, and the decision to push a refresh request.
// Assumes: inputs are the current entry after any bypass; outputs are used
// only when an event is present.
module rdm_update #(
    parameter int CNT_W = 20
) (
    input  logic             is_erase,
    input  logic [CNT_W-1:0] old_cnt,
    input  logic             old_req,
    input  logic [CNT_W-1:0] threshold,
    input  logic             q_full,
    output logic [CNT_W-1:0] new_cnt,
    output logic             new_req,
    output logic             push_req,
    output logic             sat
);

    logic at_max;
    logic over;

    // Compute the entry after one event
    always_comb begin
        at_max   = &old_cnt;
        new_cnt  = '0;
        new_req  = 1'b0;
        push_req = 1'b0;
        sat      = 1'b0;
        over     = 1'b0;
        if (!is_erase) begin
            new_cnt  = at_max ? old_cnt : old_cnt + 1'b1;
            sat      = at_max;
            over     = (new_cnt > threshold);
            push_req = over && !old_req && !q_full;
            new_req  = old_req || push_req;
        end
    end

endmodule

// File: rtl/read_disturb_monitor.sv
// Module read_disturb_monitor
// Counts page reads per flash block since the block's last erase and queues
// one refresh request per block once the count goes above the threshold.
// Pipeline: the event is sampled at edge k (RAM read issued), updated during
// the next cycle and written back at edge k+1.
// Assumes: NUM_BLOCKS is a power of two; FIFO_DEPTH is a power of two >= 2;
// threshold is held steady while events are in flight.
module read_disturb_monitor #(
    parameter int NUM_BLOCKS = 1024,
    parameter int CNT_W      = 20,
    parameter int FIFO_DEPTH = 4,
    localparam int BLK_W     = $clog2(NUM_BLOCKS),
    localparam int ENT_W     = rdm_pkg::entry_width(CNT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  logic             ev_erase,
    input  logic [BLK_W-1:0] ev_blk,
    input  logic [CNT_W-1:0] threshold,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [BLK_W-1:0] req_blk,
    output logic             sat_hit
);

    import rdm_pkg::*;

    // Stage 1: event waiting for its RAM data
    logic             s1_vld;
    rdm_op_e          s1_op;
    logic [BLK_W-1:0] s1_blk;

    // Last write-back, kept for the same-block bypass
    logic             wb_vld;
    logic [BLK_W-1:0] wb_blk;
    logic [CNT_W-1:0] wb_cnt;
    logic             wb_req;

    // Per-block "has been written since reset" marks
    logic [NUM_BLOCKS-1:0] written;

    logic [ENT_W-1:0] ram_q;
    logic [ENT_W-1:0] ram_d;
    logic [CNT_W-1:0] old_cnt;
    logic             old_req;
    logic [CNT_W-1:0] new_cnt;
    logic             new_req;
    logic             push_dec;
    logic             sat_dec;
    logic             q_full;
    logic             do_push;
    logic             do_pop;

    // Register the incoming event for the update stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_op  <= OP_READ;
            s1_blk <= '0;
        end else begin
            s1_vld <= ev_valid;
            s1_op  <= rdm_op_e'(ev_erase);
            s1_blk <= ev_blk;
        end
    end

    rdm_count_ram #(
        .DEPTH (NUM_BLOCKS),
        .WIDTH (ENT_W)
    ) u_ram (
        .clk   (clk),
        .we    (s1_vld),
        .waddr (s1_blk),
        .wdata (ram_d),
        .raddr (ev_blk),
        .rdata (ram_q)
    );

    // One written-mark per block, set by its first write-back
    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_written
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                written[g] <= 1'b0;
            end else if (s1_vld && (s1_blk == BLK_W'(g))) begin
                written[g] <= 1'b1;
            end
        end
    end

    // Select the current entry: bypass, never-written default, or RAM
    always_comb begin
        if (wb_vld && (wb_blk == s1_blk)) begin
            old_cnt = wb_cnt;
            old_req = wb_req;
        end else if (!written[s1_blk]) begin
            old_cnt = '0;
            old_req = 1'b0;
        end else begin
            old_cnt = ram_q[CNT_W-1:0];
            old_req = ram_q[CNT_W];
        end
    end

    rdm_update #(
        .CNT_W (CNT_W)
    ) u_upd (
        .is_erase  (s1_op == OP_ERASE),
        .old_cnt   (old_cnt),
        .old_req   (old_req),
        .threshold (threshold),
        .q_full    (q_full),
        .new_cnt   (new_cnt),
        .new_req   (new_req),
        .push_req  (push_dec),
        .sat       (sat_dec)
    );

    // Pack the updated entry for write-back
    always_comb begin
        ram_d   = {new_req, new_cnt};
        do_push = s1_vld && push_dec;
        do_pop  = req_valid && req_ready;
    end

    // Hold the last write-back for the bypass
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_vld <= 1'b0;
            wb_blk <= '0;
            wb_cnt <= '0;
            wb_req <= 1'b0;
        end else begin
            wb_vld <= s1_vld;
            wb_blk <= s1_blk;
            wb_cnt <= new_cnt;
            wb_req <= new_req;
        end
    end

    // Saturation pulse, one cycle per read that found the maximum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sat_hit <= 1'b0;
        end else begin
            sat_hit <= s1_vld && sat_dec;
        end
    end

    rdm_req_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (BLK_W)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (do_push),
        .push_data  (s1_blk),
        .full       (q_full),
        .pop        (do_pop),
        .head_valid (req_valid),
        .head_data  (req_blk)
    );

    AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && s1_op == OP_READ && !(&old_cnt)) |=> (wb_cnt == $past(old_cnt) + 1'b1)); // R2
    AST_PUSH_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        do_push |-> (new_cnt > threshold));                                              // R3
    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        do_push |-> !old_req);                                                           // R4
    AST_ERASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && s1_op == OP_ERASE) |=> (wb_cnt == '0 && !wb_req && !sat_hit));        // R5
    AST_SAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && s1_op == OP_READ && (&old_cnt)) |=> ((&wb_cnt) && sat_hit));          // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_vld |=> (!sat_hit && !$rose(req_valid)));                                    // R10

endmodule

// File: tb/tb_read_disturb_monitor.sv
`timescale 1ns/1ps
// Bench for read_disturb_monitor on a small configuration: 8 blocks,
// 4-bit counters (maximum 15), queue depth 2. A reference model tracks
// counts, marks and the queue; outputs are compared at falling edges.
module tb_read_disturb_monitor;

    localparam int NB   = 8;
    localparam int CW   = 4;
    localparam int FD   = 2;
    localparam int BW   = $clog2(NB);
    localparam int MAXC = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_valid = 1'b0;
    logic          ev_erase = 1'b0;
    logic [BW-1:0] ev_blk = '0;
    logic [CW-1:0] threshold = '0;
    logic          req_valid;
    logic          req_ready = 1'b0;
    logic [BW-1:0] req_blk;
    logic          sat_hit;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int m_cnt [NB];
    bit m_req [NB];
    int m_q   [FD];
    int m_qn  = 0;
    bit m_sat = 1'b0;

    always #10 clk = ~clk;

    read_disturb_monitor #(
        .NUM_BLOCKS (NB),
        .CNT_W      (CW),
        .FIFO_DEPTH (FD)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_valid  (ev_valid),
        .ev_erase  (ev_erase),
        .ev_blk    (ev_blk),
        .threshold (threshold),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_blk   (req_blk),
        .sat_hit   (sat_hit)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Reference model of one event
    task automatic model_ev(input bit er, input int b);
        m_sat = 1'b0;
        if (er) begin
            m_cnt[b] = 0;
            m_req[b] = 1'b0;
        end else begin
            if (m_cnt[b] == MAXC) m_sat = 1'b1;
            else m_cnt[b]++;
            if (m_cnt[b] > int'(threshold) && !m_req[b] && m_qn < FD) begin
                m_q[m_qn] = b;
                m_qn++;
                m_req[b] = 1'b1;
            end
        end
    endtask

    task automatic check_outs(input string tag);
        chk(tag, "req_valid", int'(req_valid), int'(m_qn > 0));
        if (m_qn > 0) chk(tag, "req_blk", int'(req_blk), m_q[0]);
        chk(tag, "sat_hit", int'(sat_hit), int'(m_sat));
    endtask

    // Present one event for one cycle (called at a falling edge)
    task automatic drive_one(input bit er, input int b);
        ev_valid = 1'b1;
        ev_erase = er;
        ev_blk   = BW'(b);
        model_ev(er, b);
        @(negedge clk);
    endtask

    task automatic settle(input string tag);
        ev_valid = 1'b0;
        @(negedge clk);
        check_outs(tag);
    endtask

    task automatic ev(input bit er, input int b, input string tag);
        drive_one(er, b);
        settle(tag);
    endtask

    task automatic pop(input string tag);
        @(negedge clk);
        m_sat = 1'b0;
        check_outs(tag);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        if (m_qn > 0) begin
            for (int i = 0; i < FD - 1; i++) m_q[i] = m_q[i + 1];
            m_qn--;
        end
        check_outs(tag);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NB; i++) begin
            m_cnt[i] = 0;
            m_req[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: quiet outputs and zero counts after reset
        chk("R1", "req_valid", int'(req_valid), 0);
        chk("R1", "sat_hit", int'(sat_hit), 0);
        threshold = CW'(1);
        ev(1'b0, 7, "R1");
        ev(1'b0, 7, "R1");
        pop("R1");

        // R10: invalid cycles touch nothing
        threshold = CW'(2);
        ev(1'b1, 4, "R10");
        ev_valid = 1'b0;
        ev_erase = 1'b0;
        ev_blk   = BW'(4);
        repeat (5) @(negedge clk);
        ev_erase = 1'b1;
        repeat (2) @(negedge clk);
        check_outs("R10");
        ev(1'b0, 4, "R10");
        ev(1'b0, 4, "R10");
        ev(1'b0, 4, "R10");
        pop("R10");

        // R3/R5: every threshold below the maximum, every block
        for (int b = 0; b < NB; b++) begin
            for (int t = 0; t < MAXC; t++) begin
                threshold = CW'(t);
                ev(1'b1, b, "R5");
                for (int r = 0; r <= t; r++) ev(1'b0, b, "R3");
                chk("R3", "request after threshold+1 reads", int'(req_valid), 1);
                pop("R9");
            end
        end

        // R4: no repeat request until erase
        threshold = CW'(2);
        ev(1'b1, 6, "R4");
        for (int r = 0; r < 3; r++) ev(1'b0, 6, "R4");
        ev(1'b0, 6, "R4");
        pop("R4");
        for (int r = 0; r < 4; r++) ev(1'b0, 6, "R4");
        chk("R4", "req_valid after more reads", int'(req_valid), 0);
        ev(1'b1, 6, "R5");
        for (int r = 0; r < 3; r++) ev(1'b0, 6, "R5");
        pop("R5");

        // R6: back-to-back events on one block
        threshold = CW'(4);
        ev(1'b1, 2, "R6");
        for (int r = 0; r < 5; r++) drive_one(1'b0, 2);
        settle("R6");
        for (int r = 0; r < 3; r++) drive_one(1'b0, 2);
        settle("R6");
        pop("R6");
        threshold = CW'(0);
        drive_one(1'b1, 2);
        drive_one(1'b0, 2);
        drive_one(1'b0, 2);
        drive_one(1'b1, 2);
        drive_one(1'b0, 2);
        settle("R6");
        pop("R6");
        pop("R6");
        threshold = CW'(3);
        ev(1'b1, 3, "R6");
        ev(1'b1, 4, "R6");
        for (int r = 0; r < 4; r++) begin
            drive_one(1'b0, 3);
            drive_one(1'b0, 4);
        end
        settle("R6");
        pop("R9");
        pop("R9");

        // R2: counts of distinct blocks stay separate
        threshold = CW'(3);
        ev(1'b1, 0, "R2");
        ev(1'b1, 1, "R2");
        ev(1'b0, 0, "R2");
        ev(1'b0, 0, "R2");
        for (int r = 0; r < 3; r++) ev(1'b0, 1, "R2");
        ev(1'b0, 0, "R2");
        ev(1'b0, 1, "R2");
        ev(1'b0, 0, "R2");
        pop("R2");
        pop("R2");

        // R7: full queue drops, later read retries
        threshold = CW'(0);
        ev(1'b1, 0, "R7");
        ev(1'b1, 1, "R7");
        ev(1'b1, 3, "R7");
        ev(1'b0, 0, "R7");
        ev(1'b0, 1, "R7");
        ev(1'b0, 3, "R7");
        chk("R7", "req_blk head stays block 0", int'(req_blk), 0);
        pop("R7");
        ev(1'b0, 3, "R7");
        pop("R9");
        pop("R7");
        chk("R9", "queue empty", int'(req_valid), 0);

        // R8: saturation holds, flags, and still compares
        threshold = CW'(MAXC);
        ev(1'b1, 5, "R8");
        for (int r = 0; r < MAXC; r++) ev(1'b0, 5, "R8");
        ev(1'b0, 5, "R8");
        ev(1'b0, 5, "R8");
        threshold = CW'(MAXC - 1);
        ev(1'b0, 5, "R8");
        pop("R8");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule